// File: doc/BRIEF.md
# Rotated-Byte Immediate Codec

This block converts between 32-bit constants and a compact 12-bit immediate field. The field holds an 8-bit payload and a 4-bit rotate count. The value it stands for is the payload rotated right by twice the rotate count. As a result, only a sparse set of 32-bit words can be written this way.

The encoder side takes a constant together with a one-cycle request. It tries the sixteen rotate counts one per clock, from smallest to largest, and stops at the first one whose inverse rotation leaves every set bit inside the low byte. It then pulses a done flag and presents a valid flag, the payload and the rotate count. A constant that fits no rotation finishes with the valid flag low. The decoder side is purely combinational: it expands any 12-bit field into its 32-bit value. It runs at all times, independently of the encoder, so both sides can be used in the same cycle.

Top module: `rotimm_codec`

## Requirements
- R1: `dec_value` always equals `dec_field[7:0]`, zero-extended to 32 bits and rotated right by 2×`dec_field[11:8]`, in the same cycle. Examples: field 0xC01 gives 256, and field 0x103 gives 0xC0000000.
- R2: A request seen while `enc_busy` is low is accepted at that clock edge, and `enc_busy` is high in the following cycle. `enc_busy` falls in exactly the cycle that `enc_done` is high.
- R3: `enc_done` is high for a single cycle per accepted request. With the request sampled at edge 0, a match at rotate count r raises `enc_done` after edge r+1. A constant with no match raises `enc_done` after edge 16.
- R4: When `enc_done` and `enc_valid` are both high, rotating `{24'b0, enc_payload}` right by 2×`enc_rot` gives back the accepted constant exactly. Examples: 256→(1,12), 384→(6,13), 484→(121,15), 16384→(1,9), 0x06000000→(6,4), 0x79000000→(121,4), 255→(255,0).
- R5: When more than one rotate count fits, the smallest is reported. A pattern that wraps around bit 31, such as 0xF000000F, encodes as (0xFF,2).
- R6: Constant 0 encodes as valid, with payload 0 and rotate 0, after the shortest latency.
- R7: A constant whose set bits do not fit one byte at any even right rotation reports `enc_valid` low, with payload 0 and rotate 0. Examples: 370, 511 and 0x06010000.
- R8: After reset, `enc_busy`, `enc_done`, `enc_valid`, `enc_payload` and `enc_rot` are all zero.
- R9: `enc_valid`, `enc_payload` and `enc_rot` change only in a cycle where `enc_done` is high. Between completions they hold.
- R10: A request raised while `enc_busy` is high is ignored. The running search completes with the result for the constant accepted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_req | input | 1 | Start an encode of `enc_value` |
| enc_value | input | 32 | Constant to encode, sampled with the request |
| enc_busy | output | 1 | Search in progress |
| enc_done | output | 1 | One-cycle completion pulse |
| enc_valid | output | 1 | Constant fits the immediate form |
| enc_payload | output | 8 | Payload byte of the result |
| enc_rot | output | 4 | Rotate count of the result (half the rotation) |
| dec_field | input | 12 | Field to expand: rotate in [11:8], payload in [7:0] |
| dec_value | output | 32 | Expanded constant |

## Verification
The encoder's search and the combinational decoder share no state, so a decode can fall in any cycle of a search, including the completion cycle. The bench starts a search on a constant that does not fit, which keeps the encoder busy for sixteen cycles. While that search runs, it steps `dec_field` through several fields and compares each expansion against values worked out by hand. It then confirms that the encode result that follows still arrives on time and has the expected contents. Outside that overlap, every completion is compared against a queued expectation that covers the flag, the payload, the rotate count and the latency in cycles.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
    localparam int WORD_W  = 32;
    localparam int PAY_W   = 8;
    localparam int ROT_W   = 4;
    localparam int FIELD_W = PAY_W + ROT_W;
    localparam int AMT_W   = ROT_W + 1;
    localparam int STEPS   = 1 << ROT_W;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              valid;
        logic [PAY_W-1:0]  payload;
        logic [ROT_W-1:0]  rot;
        logic [ROT_W-1:0]  idx;
        logic [WORD_W-1:0] value;
    } search_t;
endpackage

// File: rtl/rotimm_barrel.sv
module rotimm_barrel #(
    parameter int  W    = 32,
    parameter int  SH_W = 5,
    parameter bit  LEFT = 1'b0
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] stg [0:SH_W];

    assign stg[0] = din;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int K = (1 << s) % W;
        logic [W-1:0] moved;
        if (K == 0) begin : g_none
            assign moved = stg[s];
        end else if (LEFT) begin : g_left
            assign moved = {stg[s][W-1-K:0], stg[s][W-1:W-K]};
        end else begin : g_right
            assign moved = {stg[s][K-1:0], stg[s][W-1:K]};
        end
        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign dout = stg[SH_W];
endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
    import rotimm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] value,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic [PAY_W-1:0]  payload,
    output logic [ROT_W-1:0]  rot
);
    localparam logic [ROT_W-1:0] LAST_IDX = ROT_W'(STEPS - 1);

    search_t st_d, st_q;
    logic [WORD_W-1:0] window;
    logic              fits;

    rotimm_barrel #(.W(WORD_W), .SH_W(AMT_W), .LEFT(1'b1)) u_undo (
        .din  (st_q.value),
        .amt  ({st_q.idx, 1'b0}),
        .dout (window)
    );

    assign fits = ~|window[WORD_W-1:PAY_W];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req) begin
                st_d.busy  = 1'b1;
                st_d.value = value;
                st_d.idx   = '0;
            end
        end else if (fits) begin
            st_d.busy    = 1'b0;
            st_d.done    = 1'b1;
            st_d.valid   = 1'b1;
            st_d.payload = window[PAY_W-1:0];
            st_d.rot     = st_q.idx;
        end else if (st_q.idx == LAST_IDX) begin
            st_d.busy    = 1'b0;
            st_d.done    = 1'b1;
            st_d.valid   = 1'b0;
            st_d.payload = '0;
            st_d.rot     = '0;
        end else begin
            st_d.idx = st_q.idx + ROT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign valid   = st_q.valid;
    assign payload = st_q.payload;
    assign rot     = st_q.rot;
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec
    import rotimm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enc_req,
    input  logic [WORD_W-1:0]  enc_value,
    output logic               enc_busy,
    output logic               enc_done,
    output logic               enc_valid,
    output logic [PAY_W-1:0]   enc_payload,
    output logic [ROT_W-1:0]   enc_rot,
    input  logic [FIELD_W-1:0] dec_field,
    output logic [WORD_W-1:0]  dec_value
);
    rotimm_search u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (enc_req),
        .value   (enc_value),
        .busy    (enc_busy),
        .done    (enc_done),
        .valid   (enc_valid),
        .payload (enc_payload),
        .rot     (enc_rot)
    );

    rotimm_barrel #(.W(WORD_W), .SH_W(AMT_W), .LEFT(1'b0)) u_expand (
        .din  ({{(WORD_W-PAY_W){1'b0}}, dec_field[PAY_W-1:0]}),
        .amt  ({dec_field[FIELD_W-1:PAY_W], 1'b0}),
        .dout (dec_value)
    );
endmodule

// File: rtl/rotimm_codec_chk.sv
module rotimm_codec_chk
    import rotimm_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               enc_req,
    input logic [WORD_W-1:0]  enc_value,
    input logic               enc_busy,
    input logic               enc_done,
    input logic               enc_valid,
    input logic [PAY_W-1:0]   enc_payload,
    input logic [ROT_W-1:0]   enc_rot,
    input logic [FIELD_W-1:0] dec_field,
    input logic [WORD_W-1:0]  dec_value
);
    logic [WORD_W-1:0]   cap_q;
    logic [ROT_W:0]      run_q;
    logic [2*WORD_W-1:0] enc_dbl, dec_dbl;
    logic [WORD_W-1:0]   enc_back, dec_ref;
    logic [WORD_W-1:0]   enc_ext, dec_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            run_q <= '0;
        end else begin
            if (enc_req && !enc_busy) begin
                cap_q <= enc_value;
                run_q <= '0;
            end else if (enc_busy) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    always_comb begin
        enc_ext  = {{(WORD_W-PAY_W){1'b0}}, enc_payload};
        dec_ext  = {{(WORD_W-PAY_W){1'b0}}, dec_field[PAY_W-1:0]};
        enc_dbl  = {enc_ext, enc_ext} >> {enc_rot, 1'b0};
        dec_dbl  = {dec_ext, dec_ext} >> {dec_field[FIELD_W-1:PAY_W], 1'b0};
        enc_back = enc_dbl[WORD_W-1:0];
        dec_ref  = dec_dbl[WORD_W-1:0];
    end

    AST_DECODE_EXPANDS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_value == dec_ref); // R1
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enc_busy) == enc_done); // R2
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_req && !enc_busy) |=> enc_busy); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done |=> !enc_done); // R3
    AST_SEARCH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        enc_busy |-> (run_q < (ROT_W+1)'(STEPS))); // R3
    AST_RESULT_REBUILDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_done && enc_valid) |-> (enc_back == cap_q)); // R4
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_done && !enc_valid) |-> (enc_payload == '0 && enc_rot == '0)); // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_done |-> ($stable(enc_valid) && $stable(enc_payload) && $stable(enc_rot))); // R9
endmodule

bind rotimm_codec rotimm_codec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_req     (enc_req),
    .enc_value   (enc_value),
    .enc_busy    (enc_busy),
    .enc_done    (enc_done),
    .enc_valid   (enc_valid),
    .enc_payload (enc_payload),
    .enc_rot     (enc_rot),
    .dec_field   (dec_field),
    .dec_value   (dec_value)
);

// File: tb/rotimm_codec_test.sv
`timescale 1ns/1ps
module rotimm_codec_test;
    import rotimm_pkg::*;

    typedef struct {
        logic       valid;
        logic [7:0] n;
        logic [3:0] r;
        int         lat;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_req = 1'b0;
    logic [31:0] enc_value = '0;
    logic        enc_busy, enc_done, enc_valid;
    logic [7:0]  enc_payload;
    logic [3:0]  enc_rot;
    logic [11:0] dec_field = '0;
    logic [31:0] dec_value;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t0 = 0;
    bit finished = 1'b0;
    exp_t expq[$];
    exp_t last;

    always #2 clk = ~clk;

    rotimm_codec uut (
        .clk(clk), .rst_n(rst_n), .enc_req(enc_req), .enc_value(enc_value),
        .enc_busy(enc_busy), .enc_done(enc_done), .enc_valid(enc_valid),
        .enc_payload(enc_payload), .enc_rot(enc_rot),
        .dec_field(dec_field), .dec_value(dec_value)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare at each completion
    always @(negedge clk) begin
        if (rst_n && enc_done) begin
            if (expq.size() == 0) begin
                check("R3 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " valid"}, 32'(enc_valid), 32'(e.valid));
                check({e.tag, " payload"}, 32'(enc_payload), 32'(e.n));
                check({e.tag, " rot"}, 32'(enc_rot), 32'(e.r));
                check("R3 latency", 32'(cyc - t0), 32'(e.lat));
                last = e;
            end
        end
    end

    // Driver: queue the expectation, raise the request, wait for completion
    task automatic encode(input logic [31:0] v, input logic ev, input logic [7:0] en,
                          input logic [3:0] er, input string tag, input bit poke);
        exp_t e;
        e.valid = ev; e.n = en; e.r = er; e.tag = tag;
        e.lat = ev ? int'(er) + 2 : 17;
        expq.push_back(e);
        @(negedge clk);
        enc_req = 1'b1; enc_value = v; t0 = cyc;
        @(negedge clk);
        if (poke) begin
            enc_value = ~v;   // R10: request while busy must be ignored
            repeat (3) @(negedge clk);
        end
        enc_req = 1'b0;
        while (expq.size() != 0) @(negedge clk);
    endtask

    task automatic dec_check(input logic [11:0] f, input logic [31:0] exp);
        dec_field = f;
        #1;
        check("R1 decode", dec_value, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 busy", 32'(enc_busy), 0);
        check("R8 done", 32'(enc_done), 0);
        check("R8 valid", 32'(enc_valid), 0);
        check("R8 payload", 32'(enc_payload), 0);
        check("R8 rot", 32'(enc_rot), 0);
        rst_n = 1'b1;

        encode(32'd256,        1, 8'd1,   4'd12, "R4 256", 0);
        encode(32'd384,        1, 8'd6,   4'd13, "R4 384", 0);
        encode(32'd484,        1, 8'd121, 4'd15, "R4 484", 0);
        encode(32'd16384,      1, 8'd1,   4'd9,  "R5 16384", 0);
        encode(32'h0600_0000,  1, 8'd6,   4'd4,  "R4 0x06000000", 0);
        encode(32'h7900_0000,  1, 8'd121, 4'd4,  "R4 0x79000000", 0);
        encode(32'd255,        1, 8'd255, 4'd0,  "R4 255", 0);
        encode(32'hF000_000F,  1, 8'hFF,  4'd2,  "R5 wrap", 0);
        encode(32'd0,          1, 8'd0,   4'd0,  "R6 zero", 0);
        encode(32'd370,        0, 8'd0,   4'd0,  "R7 370", 0);
        encode(32'h0601_0000,  0, 8'd0,   4'd0,  "R7 0x06010000", 0);

        // R9: outputs hold after completion
        encode(32'h0000_0300,  1, 8'd3,   4'd12, "R4 0x300", 0);
        repeat (4) @(negedge clk);
        check("R9 hold valid", 32'(enc_valid), 1);
        check("R9 hold payload", 32'(enc_payload), 8'd3);
        check("R9 hold rot", 32'(enc_rot), 4'd12);

        // R10: request held high while busy with a changed value
        encode(32'h0000_0FF0,  1, 8'hFF,  4'd14, "R10 ignore busy req", 1);

        // R1 concurrent with a full-length failing search (R7 511)
        fork
            encode(32'd511, 0, 8'd0, 4'd0, "R7 511", 0);
            begin
                repeat (3) @(negedge clk);
                dec_check(12'hC01, 32'd256);
                dec_check(12'hF79, 32'd484);
                dec_check(12'h4FF, 32'hFF00_0000);
                dec_check(12'h0AB, 32'h0000_00AB);
                dec_check(12'h103, 32'hC000_0000);
                dec_check(12'h881, 32'h0081_0000);
            end
        join
        dec_check(12'h000, 32'd0);

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule